// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps the five interrupt status bits of a 16-bit timer/counter. The bits are input capture, three output-compare channels (A, B and C) and overflow. It watches the running count, the compare values, the capture value and a set of event strobes. From these it decides when each status bit rises. A bit falls when the interrupt controller acknowledges that bit's vector, or when software writes a one to the bit's position. Each bit also drives an interrupt request, and that request is qualified by a per-bit enable.

The counter, the waveform generator and the interrupt controller sit outside this block. The block takes their results as inputs: the count, a timer-clock enable pulse, a capture strobe, a flag saying whether the capture register acts as TOP, forced-compare strobes, and an overflow strobe with its mode qualifier.

Top module: `tmr_irq_flags`

## Requirements
- R1: With `cap_is_top` low, a `cap_evt` pulse sampled at a clock edge makes `flags[5]` read 1 after that edge.
- R2: With `cap_is_top` high, `cap_evt` is ignored. `flags[5]` instead reads 1 after an edge where `tick` is high and `cnt` equals `cap_val`.
- R3: Consider an edge where `tick` is high and `cnt` equals compare channel k. Channel k is bits [16k+15:16k] of `cmp_val`, with k = 0, 1, 2 for A, B, C. Its flag is bit k+1 of `flags`. That flag is still 0 after this edge and reads 1 only after the next clock edge.
- R4: A compare flag sets once per entry into a match. While `cnt` stays equal to the compare value over further ticks, a flag cleared in that window stays clear. It sets again only after `cnt` has left the value and come back.
- R5: A forced-compare strobe (`frc[k]`) never sets compare flag k.
- R6: `flags[0]` sets after an edge where `ovf_evt` and `ovf_mode_ok` are both high. `ovf_evt` with `ovf_mode_ok` low is ignored.
- R7: `ack[b]` high at an edge clears `flags[b]`.
- R8: A write (`wr_en` high) clears each flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 are left unchanged.
- R9: When a set event and a clear (acknowledge or write-one) meet on the same flag at the same edge, the flag reads 1 afterwards.
- R10: Bits 7, 6 and 4 of `flags` always read 0, and writes to them do nothing.
- R11: `irq[b]` equals `flags[b]` AND `ien[b]` for every bit.
- R12: While `rst_n` is low, all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer-clock enable; compare and TOP detection happen only on ticks |
| cnt | input | 16 | Running counter value |
| cmp_val | input | 48 | Compare values; channel A in bits [15:0], B in [31:16], C in [47:32] |
| cap_val | input | 16 | Capture register value, used as TOP when `cap_is_top` is high |
| cap_evt | input | 1 | Capture input event strobe |
| cap_is_top | input | 1 | High when the capture register serves as the counter TOP |
| frc | input | 3 | Forced-compare strobes, one per channel |
| ovf_evt | input | 1 | Counter overflow strobe |
| ovf_mode_ok | input | 1 | High when the waveform mode lets overflow set the flag |
| ack | input | 8 | Per-bit vector acknowledge pulses |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a one clears that flag |
| ien | input | 8 | Per-bit interrupt enables |
| flags | output | 8 | Flag register read value |
| irq | output | 8 | Per-bit interrupt requests |

## Verification
The bench first checks that a compare flag is still clear one edge after the match and set one edge later. A design that sets the flag in the match cycle fails this at once. It then holds the count on a compare value across several ticks and clears the flag in between. A design that re-arms on every equal tick would set the flag again there. It also fires a set event together with an acknowledge, and together with a write-one, on the same bit. A design where the clear wins loses the event and reads 0. Finally it sends capture strobes in TOP mode and overflow strobes with the mode qualifier low. A design that leaks either one shows a set bit where none is expected.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
   localparam int OVF_BIT  = 0;
   localparam int CMP_BIT0 = 1;
   localparam int CAP_BIT  = 5;
   localparam int MAX_CMP  = 3;

   // Mask of implemented flag positions for a given channel count
   function automatic logic [31:0] impl_mask(input int n_cmp);
      logic [31:0] m;
      m = '0;
      m[OVF_BIT] = 1'b1;
      m[CAP_BIT] = 1'b1;
      for (int i = 0; i < n_cmp; i++) m[CMP_BIT0 + i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/tmr_cmp_detect.sv
module tmr_cmp_detect #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   output logic             hit
);
   logic eq_now;
   logic eq_q;

   assign eq_now = (cnt == cmp);

   // Equality state follows ticks; hit pulses for one cycle on a fresh entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eq_q <= 1'b0;
         hit  <= 1'b0;
      end else if (tick) begin
         eq_q <= eq_now;
         hit  <= eq_now & ~eq_q;
      end else begin
         hit  <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_cap_src.sv
module tmr_cap_src #(
   parameter int CNT_W = 16
) (
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cap_val,
   input  logic             cap_evt,
   input  logic             cap_is_top,
   output logic             set
);
   always_comb begin
      if (cap_is_top) set = tick & (cnt == cap_val);
      else            set = cap_evt;
   end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // Set has priority over clear so no event is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
   import tmr_flag_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int N_CMP = 3,
   parameter int REG_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic [CNT_W-1:0]       cnt,
   input  logic [N_CMP*CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0]       cap_val,
   input  logic                   cap_evt,
   input  logic                   cap_is_top,
   input  logic [N_CMP-1:0]       frc,
   input  logic                   ovf_evt,
   input  logic                   ovf_mode_ok,
   input  logic [REG_W-1:0]       ack,
   input  logic                   wr_en,
   input  logic [REG_W-1:0]       wr_data,
   input  logic [REG_W-1:0]       ien,
   output logic [REG_W-1:0]       flags,
   output logic [REG_W-1:0]       irq
);
   localparam logic [31:0]      MASK32 = impl_mask(N_CMP);
   localparam logic [REG_W-1:0] IMPL   = MASK32[REG_W-1:0];

   if (N_CMP < 1 || N_CMP > MAX_CMP) begin : g_bad_ncmp
      $error("tmr_irq_flags: N_CMP out of range");
   end
   if (REG_W < CAP_BIT + 1) begin : g_bad_regw
      $error("tmr_irq_flags: REG_W too narrow");
   end
   if (CNT_W < 2) begin : g_bad_cntw
      $error("tmr_irq_flags: CNT_W too narrow");
   end

   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;
   logic [N_CMP-1:0] cmp_hit;
   logic             cap_set;

   // Forced-compare strobes are accepted but never feed the set path
   logic unused_frc;
   assign unused_frc = ^frc;

   for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
      tmr_cmp_detect #(.CNT_W(CNT_W)) u_det (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick),
         .cnt  (cnt),
         .cmp  (cmp_val[k*CNT_W +: CNT_W]),
         .hit  (cmp_hit[k])
      );
   end

   tmr_cap_src #(.CNT_W(CNT_W)) u_cap (
      .tick      (tick),
      .cnt       (cnt),
      .cap_val   (cap_val),
      .cap_evt   (cap_evt),
      .cap_is_top(cap_is_top),
      .set       (cap_set)
   );

   always_comb begin
      set_vec = '0;
      set_vec[OVF_BIT] = ovf_evt & ovf_mode_ok;
      set_vec[CAP_BIT] = cap_set;
      for (int k = 0; k < N_CMP; k++) set_vec[CMP_BIT0 + k] = cmp_hit[k];
   end

   assign clr_vec = ack | (wr_en ? wr_data : '0);

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (IMPL[b]) begin : g_flag
         tmr_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_vec[b]),
            .clr  (clr_vec[b]),
            .q    (flags[b])
         );
      end else begin : g_rsvd
         assign flags[b] = 1'b0;
      end
   end

   assign irq = flags & ien;
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk #(
   parameter int CNT_W = 16,
   parameter int N_CMP = 3,
   parameter int REG_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tick,
   input logic [CNT_W-1:0]       cnt,
   input logic [N_CMP*CNT_W-1:0] cmp_val,
   input logic                   cap_evt,
   input logic                   cap_is_top,
   input logic                   ovf_evt,
   input logic                   ovf_mode_ok,
   input logic [REG_W-1:0]       ack,
   input logic                   wr_en,
   input logic [REG_W-1:0]       wr_data,
   input logic [REG_W-1:0]       ien,
   input logic [REG_W-1:0]       flags,
   input logic [REG_W-1:0]       irq
);
   a_r1_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && !cap_is_top) |=> flags[5]);

   a_r3_cmp_a_late: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> $past(tick && (cnt == cmp_val[CNT_W-1:0]), 2));

   a_r6_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && ovf_mode_ok) |=> flags[0]);

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[0] && !(ovf_evt && ovf_mode_ok)) |=> !flags[0]);

   a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && !(ovf_evt && ovf_mode_ok)) |=> !flags[0]);

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && ovf_mode_ok && (ack[0] || (wr_en && wr_data[0]))) |=> flags[0]);

   a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[7:6] == 2'b00) && !flags[4]);

   a_r11_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~ien) == '0) && ((irq & ~flags) == '0));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP), .REG_W(REG_W)) u_chk (.*);

// File: tb/tmr_irq_flags_tb.sv
module tmr_irq_flags_tb;
   localparam int CLK_P = 10;

   typedef struct {
      logic [7:0] f;
      logic [7:0] i;
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick;
   logic [15:0] cnt;
   logic [47:0] cmp_val;
   logic [15:0] cap_val;
   logic        cap_evt, cap_is_top, ovf_evt, ovf_mode_ok, wr_en;
   logic [2:0]  frc;
   logic [7:0]  ack, wr_data, ien, flags, irq;

   logic        s_tick, s_cap, s_top, s_ovf, s_ok, s_wr;
   logic [15:0] s_cnt;
   logic [2:0]  s_frc;
   logic [7:0]  s_ack, s_wdata, s_ien;

   exp_t q[$];
   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   tmr_irq_flags u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp_val(cmp_val),
      .cap_val(cap_val), .cap_evt(cap_evt), .cap_is_top(cap_is_top), .frc(frc),
      .ovf_evt(ovf_evt), .ovf_mode_ok(ovf_mode_ok), .ack(ack), .wr_en(wr_en),
      .wr_data(wr_data), .ien(ien), .flags(flags), .irq(irq)
   );

   // Driver: applies staged inputs at the falling edge, queues the result due after the next rise
   task automatic step(input logic [7:0] ef, input string req);
      exp_t e;
      @(negedge clk);
      tick = s_tick; cnt = s_cnt; cap_evt = s_cap; cap_is_top = s_top;
      frc = s_frc; ovf_evt = s_ovf; ovf_mode_ok = s_ok; ack = s_ack;
      wr_en = s_wr; wr_data = s_wdata; ien = s_ien;
      e.f = ef; e.i = ef & s_ien; e.req = req;
      q.push_back(e);
      s_cap = 0; s_frc = '0; s_ovf = 0; s_ack = '0; s_wr = 0; s_wdata = '0;
   endtask

   // Monitor: compares a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (flags !== e.f || irq !== e.i) begin
               errors++;
               $display("FAIL %s: flags=%h irq=%h expected flags=%h irq=%h",
                        e.req, flags, irq, e.f, e.i);
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_P*5000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      rst_n = 0; tick = 0; cnt = 16'd100; cap_evt = 0; cap_is_top = 0; frc = 0;
      ovf_evt = 0; ovf_mode_ok = 0; ack = 0; wr_en = 0; wr_data = 0; ien = 0;
      cmp_val = {16'd30, 16'd20, 16'd10}; cap_val = 16'd40;
      s_tick = 1; s_cnt = 16'd100; s_cap = 0; s_top = 0; s_frc = 0; s_ovf = 0;
      s_ok = 0; s_ack = 0; s_wr = 0; s_wdata = 0; s_ien = 0;
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      checks++;
      if (flags !== 8'h00) begin
         errors++;
         $display("FAIL R12: flags=%h expected 00", flags);
      end
      @(negedge clk); rst_n = 1;

      step(8'h00, "R12 after reset");
      s_cap = 1;                      step(8'h20, "R1 capture");
      s_ack = 8'h20;                  step(8'h00, "R7 ack capture");
      s_cnt = 16'd10;                 step(8'h00, "R3 not in match cycle");
      s_cnt = 16'd11;                 step(8'h02, "R3 A one cycle later");
      s_wr = 1; s_wdata = 8'h00;      step(8'h02, "R8 write zero keeps");
      s_wr = 1; s_wdata = 8'hFF;      step(8'h00, "R8 write one clears");
      s_cnt = 16'd20;                 step(8'h00, "R3 B match cycle");
      step(8'h04, "R3 B set");
      s_ack = 8'h04;                  step(8'h00, "R4 ack while held");
      step(8'h00, "R4 no reset while held");
      step(8'h00, "R4 still held");
      s_cnt = 16'd21;                 step(8'h00, "R4 leave");
      s_cnt = 16'd20;                 step(8'h00, "R4 re-entry cycle");
      step(8'h04, "R4 re-entry sets");
      s_ack = 8'h04; s_cnt = 16'd100; step(8'h00, "R7 ack B");
      s_frc = 3'b111;                 step(8'h00, "R5 forced strobes");
      step(8'h00, "R5 no late set");
      s_cnt = 16'd30;                 step(8'h00, "R3 C match cycle");
      s_cnt = 16'd31;                 step(8'h08, "R3 C set");
      s_wr = 1; s_wdata = 8'h08;      step(8'h00, "R8 clear C");
      s_ovf = 1; s_ok = 0;            step(8'h00, "R6 overflow masked");
      s_ovf = 1; s_ok = 1;            step(8'h01, "R6 overflow sets");
      s_ack = 8'h01;                  step(8'h00, "R7 ack overflow");
      s_ovf = 1; s_ack = 8'h01;       step(8'h01, "R9 set beats ack");
      s_cap = 1; s_wr = 1; s_wdata = 8'h21; step(8'h20, "R9 set beats write");
      s_ien = 8'h21;                  step(8'h20, "R11 enabled irq");
      s_ien = 8'h01;                  step(8'h20, "R11 disabled irq");
      s_wr = 1; s_wdata = 8'h20;      step(8'h00, "R8 clear capture");
      s_ien = 8'hFF; s_top = 1; s_cap = 1; step(8'h00, "R2 event ignored as TOP");
      s_cnt = 16'd40;                 step(8'h20, "R2 TOP reached");
      s_cnt = 16'd41; s_ack = 8'h20;  step(8'h00, "R7 ack TOP flag");
      s_wr = 1; s_wdata = 8'hD0;      step(8'h00, "R10 reserved write");
      s_top = 0; s_cap = 1; s_ovf = 1; s_cnt = 16'd10; step(8'h21, "R10 reserved stay zero");
      step(8'h23, "R11 all enabled");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule